// File: doc/BRIEF.md
# Shifter Operand and Flag Unit

This block forms the second operand of a 32-bit data-processing instruction and then executes one of sixteen ALU operations on it, returning the result, the new condition flags and a write-enable for the destination. The second operand is either a small immediate rotated right by an even amount, or a register value passed through a barrel shifter. The shift amount comes from a 5-bit immediate field or from the low byte of another register.

The shifter handles the encoding corner cases in full. A zero immediate amount means 32 for the two right shifts and a one-bit rotate through carry for rotate. Register amounts of 32 and above follow their own carry rules. The shifter carry feeds the C flag of the logical operations. The adder serves all eight arithmetic operations through operand swapping and inversion. The surrounding core supplies the operand values and the current flags, and consumes the registered outputs one cycle later. Register reads, write-back and fetch belong to the core.

Top module: `sau_top`

## Requirements
- R1: With `imm_form`=1 the operand is `imm_byte` zero-extended and rotated right by 2×`imm_rot`; the shifter carry is bit 31 of that value when `imm_rot`≠0 and the incoming C flag when `imm_rot`=0.
- R2: Left shift (`sh_kind`=0): an amount of 0 leaves value and carry unchanged; amounts 1..31 give carry = the last bit shifted out; a register amount of 32 gives 0 with carry = bit 0; a register amount above 32 gives 0 with carry 0.
- R3: Logical right shift (`sh_kind`=1): an immediate amount of 0 acts as 32 (result 0, carry = bit 31); amounts 1..31 give carry = bit (amount−1); a register amount above 32 gives 0 with carry 0.
- R4: Arithmetic right shift (`sh_kind`=2): an immediate amount of 0 acts as 32; any amount of 32 or more fills every bit with bit 31, and the carry equals bit 31.
- R5: Rotate (`sh_kind`=3) with an immediate amount of 0 is a one-bit rotate through carry: the incoming C enters bit 31 and old bit 0 becomes the carry.
- R6: Rotate by a register amount: an amount of 0 keeps value and carry; a nonzero multiple of 32 keeps the value and sets the carry to bit 31; otherwise the value is rotated by amount mod 32 and the carry is the new bit 31.
- R7: A register shift amount uses only `sh_amt_reg[7:0]`; higher bits have no effect.
- R8: The logical operations (`alu_op` 0 AND, 1 EOR, 12 ORR, 13 MOV, 14 BIC, 15 MVN, 8 TST, 9 TEQ) set C from the shifter carry, keep V, set Z on a zero result and copy bit 31 into N.
- R9: The arithmetic operations compute x + ~y + cin for subtraction (2 SUB and 10 CMP: a−b with cin 1; 3 RSB: b−a, cin 1; 6 SBC: a−b, cin C; 7 RSC: b−a, cin C) and x + y + cin for addition (4 ADD and 11 CMN: cin 0; 5 ADC: cin C); C is the carry out of bit 31 and V is set when both adder inputs share a sign that differs from the sign of the result.
- R10: The four compare and test operations (`alu_op` 8..11) update the flags even with `set_flags`=0 and hold `dest_we` low; all other operations raise `dest_we`.
- R11: With `set_flags`=0 and a non-compare operation, `flags_out` equals `flags_in`. Flags are packed as {N,Z,C,V} in bits 3..0.
- R12: The outputs are registered with one cycle of latency. A synchronous `rst` clears `out_vld`, `result`, `flags_out` and `dest_we`. A cycle with `in_vld`=0 leaves `result`, `flags_out` and `dest_we` unchanged and drops `out_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operation present this cycle |
| alu_op | input | 4 | Operation code (see R8, R9) |
| set_flags | input | 1 | Update flags for non-compare operations |
| imm_form | input | 1 | 1: rotated immediate operand, 0: shifted register |
| imm_byte | input | 8 | Immediate byte |
| imm_rot | input | 4 | Immediate rotate field (rotate by twice this) |
| sh_kind | input | 2 | 0 left, 1 logical right, 2 arithmetic right, 3 rotate |
| sh_by_reg | input | 1 | Shift amount taken from `sh_amt_reg` |
| sh_amt_imm | input | 5 | Immediate shift amount |
| sh_amt_reg | input | 32 | Register holding the shift amount |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Register to be shifted |
| flags_in | input | 4 | Current {N,Z,C,V} |
| out_vld | output | 1 | Registered result valid |
| result | output | 32 | Operation result |
| flags_out | output | 4 | New {N,Z,C,V} |
| dest_we | output | 1 | Destination should be written |

## Verification
The operand path is probed with MOV and flag setting on, so the shifted value and the shifter carry show up directly as the result and C. Every shift kind is tried with amount 0, an ordinary amount, exactly 32 and above 32, with bit patterns placed so that the bit expected in C differs from its neighbours. The incoming C is chosen opposite to what a wrong carry source would produce. Each arithmetic operation gets operands that separate a missing or inverted carry-in, swapped operands and signed overflow from unsigned carry. The compare, no-update and hold cases use incoming flags that would be visibly overwritten if the update were wrongly enabled.

// File: rtl/sau_pkg.sv
package sau_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } sh_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  function automatic logic is_compare(alu_op_e op);
    return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
  endfunction

  function automatic logic is_arith(alu_op_e op);
    return (op == OP_SUB) || (op == OP_RSB) || (op == OP_ADD) || (op == OP_ADC) ||
           (op == OP_SBC) || (op == OP_RSC) || (op == OP_CMP) || (op == OP_CMN);
  endfunction

endpackage

// File: rtl/sau_imm_rot.sv
module sau_imm_rot #(
  parameter int DW    = 32,
  parameter int IMM_W = 8,
  parameter int ROT_W = 4
) (
  input  logic [IMM_W-1:0] imm_byte,
  input  logic [ROT_W-1:0] imm_rot,
  input  logic             cin,
  output logic [DW-1:0]    val,
  output logic             cout
);
  localparam int RA_W = ROT_W + 1;

  logic [DW-1:0]   ext;
  logic [RA_W-1:0] amt;
  logic [2*DW-1:0] dbl;

  always_comb begin
    ext  = DW'(imm_byte);
    amt  = {imm_rot, 1'b0};
    dbl  = {ext, ext} >> amt;
    val  = dbl[DW-1:0];
    cout = (imm_rot != '0) ? dbl[DW-1] : cin;
  end

  always_comb begin
    if (!$isunknown({imm_byte, imm_rot})) begin
      // R1
      imm_rot_ones_chk: assert ($countones(val) == $countones(imm_byte));
    end
  end

endmodule

// File: rtl/sau_shifter.sv
module sau_shifter
  import sau_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AMT_W = 8
) (
  input  logic [DW-1:0]         v,
  input  sh_kind_e              kind,
  input  logic                  by_reg,
  input  logic [$clog2(DW)-1:0] amt_imm,
  input  logic [DW-1:0]         amt_reg,
  input  logic                  cin,
  output logic [DW-1:0]         val,
  output logic                  cout
);
  localparam int SA_W = $clog2(DW);
  localparam int SW   = (AMT_W > SA_W ? AMT_W : SA_W) + 1;
  localparam logic [SW-1:0] DWN = SW'(DW);

  logic [SW-1:0]          n;
  logic [SW-1:0]          nc;
  logic                   big;
  logic                   rrx;
  logic [DW:0]            lsl_w;
  logic [DW:0]            lsr_w;
  logic signed [DW:0]     asr_w;
  logic [2*DW-1:0]        rdbl;
  logic [SA_W-1:0]        r;

  // effective amount: register low byte, or immediate with 0 meaning DW for right shifts
  always_comb begin
    if (by_reg)
      n = SW'(amt_reg[AMT_W-1:0]);
    else if ((amt_imm == '0) && ((kind == SH_LSR) || (kind == SH_ASR)))
      n = DWN;
    else
      n = SW'(amt_imm);
    rrx = !by_reg && (kind == SH_ROR) && (amt_imm == '0);
    big = (n > DWN);
    nc  = big ? DWN : n;
    r   = n[SA_W-1:0];
  end

  always_comb begin
    lsl_w = {1'b0, v} << nc;
    lsr_w = {v, 1'b0} >> nc;
    asr_w = $signed({v, 1'b0}) >>> nc;
    rdbl  = {v, v} >> r;
  end

  always_comb begin
    val  = v;
    cout = cin;
    if (rrx) begin
      val  = {cin, v[DW-1:1]};
      cout = v[0];
    end else if (n != '0) begin
      unique case (kind)
        SH_LSL: begin
          val  = big ? '0 : lsl_w[DW-1:0];
          cout = big ? 1'b0 : lsl_w[DW];
        end
        SH_LSR: begin
          val  = big ? '0 : lsr_w[DW:1];
          cout = big ? 1'b0 : lsr_w[0];
        end
        SH_ASR: begin
          val  = asr_w[DW:1];
          cout = asr_w[0];
        end
        default: begin
          val  = rdbl[DW-1:0];
          cout = rdbl[DW-1];
        end
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({v, kind, by_reg, amt_imm, amt_reg, cin})) begin
      // R4
      asr_sign_chk: assert ((kind != SH_ASR) || (val[DW-1] == v[DW-1]));
      // R6
      ror_ones_chk: assert ((kind != SH_ROR) || rrx || ($countones(val) == $countones(v)));
    end
  end

endmodule

// File: rtl/sau_alu.sv
module sau_alu
  import sau_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          shc,
  input  flags_t        fin,
  input  logic          set_flags,
  output logic [DW-1:0] r,
  output flags_t        fout,
  output logic          wr
);
  logic [DW-1:0] x, y, lres;
  logic          ci, arith, upd;
  logic [DW:0]   sum;

  // one shared adder: operands swapped and inverted per operation
  always_comb begin
    x  = a;
    y  = b;
    ci = 1'b0;
    unique case (op)
      OP_SUB, OP_CMP: begin y = ~b; ci = 1'b1;  end
      OP_RSB:         begin x = b; y = ~a; ci = 1'b1; end
      OP_ADC:         begin ci = fin.c; end
      OP_SBC:         begin y = ~b; ci = fin.c; end
      OP_RSC:         begin x = b; y = ~a; ci = fin.c; end
      default:        ;
    endcase
    sum = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
  end

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: lres = a & b;
      OP_EOR, OP_TEQ: lres = a ^ b;
      OP_ORR:         lres = a | b;
      OP_BIC:         lres = a & ~b;
      OP_MVN:         lres = ~b;
      default:        lres = b;
    endcase
  end

  always_comb begin
    arith = is_arith(op);
    upd   = set_flags || is_compare(op);
    wr    = !is_compare(op);
    r     = arith ? sum[DW-1:0] : lres;
    fout  = fin;
    if (upd) begin
      fout.n = r[DW-1];
      fout.z = (r == '0);
      fout.c = arith ? sum[DW] : shc;
      fout.v = arith ? (~(x[DW-1] ^ y[DW-1]) & (x[DW-1] ^ sum[DW-1])) : fin.v;
    end
  end

  always_comb begin
    if (!$isunknown({op, fin, set_flags})) begin
      // R8
      logic_keeps_v_chk: assert (is_arith(op) || (fout.v == fin.v));
    end
  end

endmodule

// File: rtl/sau_top.sv
module sau_top
  import sau_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IMM_W = 8,
  parameter int ROT_W = 4,
  parameter int AMT_W = 8,
  localparam int SA_W = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [3:0]       alu_op,
  input  logic             set_flags,
  input  logic             imm_form,
  input  logic [IMM_W-1:0] imm_byte,
  input  logic [ROT_W-1:0] imm_rot,
  input  logic [1:0]       sh_kind,
  input  logic             sh_by_reg,
  input  logic [SA_W-1:0]  sh_amt_imm,
  input  logic [DW-1:0]    sh_amt_reg,
  input  logic [DW-1:0]    opnd_a,
  input  logic [DW-1:0]    opnd_b,
  input  logic [3:0]       flags_in,
  output logic             out_vld,
  output logic [DW-1:0]    result,
  output logic [3:0]       flags_out,
  output logic             dest_we
);
  flags_t        fin;
  logic [DW-1:0] imm_val, sh_val, op2, alu_r;
  logic          imm_c, sh_c, op2_c, alu_we;
  flags_t        alu_f;

  assign fin = flags_t'(flags_in);

  sau_imm_rot #(.DW(DW), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
    .imm_byte (imm_byte),
    .imm_rot  (imm_rot),
    .cin      (fin.c),
    .val      (imm_val),
    .cout     (imm_c)
  );

  sau_shifter #(.DW(DW), .AMT_W(AMT_W)) u_sh (
    .v       (opnd_b),
    .kind    (sh_kind_e'(sh_kind)),
    .by_reg  (sh_by_reg),
    .amt_imm (sh_amt_imm),
    .amt_reg (sh_amt_reg),
    .cin     (fin.c),
    .val     (sh_val),
    .cout    (sh_c)
  );

  assign op2   = imm_form ? imm_val : sh_val;
  assign op2_c = imm_form ? imm_c : sh_c;

  sau_alu #(.DW(DW)) u_alu (
    .op        (alu_op_e'(alu_op)),
    .a         (opnd_a),
    .b         (op2),
    .shc       (op2_c),
    .fin       (fin),
    .set_flags (set_flags),
    .r         (alu_r),
    .fout      (alu_f),
    .wr        (alu_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      result    <= '0;
      flags_out <= '0;
      dest_we   <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        result    <= alu_r;
        flags_out <= alu_f;
        dest_we   <= alu_we;
      end
    end
  end

  // R10
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && alu_op[3:2] == 2'b10) |=> !dest_we);

  // R11
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !set_flags && alu_op[3:2] != 2'b10) |=> (flags_out == $past(flags_in)));

  // R12
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_vld && result == '0 && flags_out == '0 && !dest_we));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_vld && !$past(rst)) |=> ($stable(result) && $stable(flags_out) && !out_vld));

endmodule

// File: tb/sim_sau_top.sv
module sim_sau_top;

  typedef struct packed {
    logic [3:0]  op;
    logic        sf;
    logic        imf;
    logic [7:0]  ib;
    logic [3:0]  ir;
    logic [1:0]  k;
    logic        br;
    logic [4:0]  ai;
    logic [31:0] ar;
    logic [31:0] a;
    logic [31:0] b;
    logic [3:0]  fi;
    logic [31:0] er;
    logic [3:0]  ef;
    logic        ew;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 40;
  // fields: op sf imf ib ir k br ai ar a b fi | exp result, exp flags {N,Z,C,V}, exp we, requirement
  localparam vec_t TBL [NV] = '{
    // R1 rotated immediates
    '{4'd13,1'b1,1'b1,8'hFF,4'd4,2'd0,1'b0,5'd0,32'd0,32'd0,32'd0,4'b0000,32'hFF000000,4'b1010,1'b1,8'd1},
    '{4'd13,1'b1,1'b1,8'h80,4'd0,2'd0,1'b0,5'd0,32'd0,32'd0,32'd0,4'b0010,32'h00000080,4'b0010,1'b1,8'd1},
    '{4'd13,1'b1,1'b1,8'h01,4'd1,2'd0,1'b0,5'd0,32'd0,32'd0,32'd0,4'b0010,32'h40000000,4'b0000,1'b1,8'd1},
    // R2 left shift
    '{4'd13,1'b1,1'b0,8'h00,4'd0,2'd0,1'b0,5'd0,32'd0,32'd0,32'h80000001,4'b0010,32'h80000001,4'b1010,1'b1,8'd2},
    '{4'd13,1'b1,1'b0,8'h00,4'd0,2'd0,1'b0,5'd4,32'd0,32'd0,32'h1000000F,4'b0000,32'h000000F0,4'b0010,1'b1,8'd2},
    '{4'd13,1'b1,1'b0,8'h00,4'd0,2'd0,1'b1,5'd0,32'd32,32'd0,32'h00000001,4'b0001,32'h00000000,4'b0111,1'b1,8'd2},
    '{4'd13,1'b1,1'b0,8'h00,4'd0,2'd0,1'b1,5'd0,32'd33,32'd0,32'hFFFFFFFF,4'b0010,32'h00000000,4'b0100,1'b1,8'd2},
    // R3 logical right shift
    '{4'd13,1'b1,1'b0,8'h00,4'd0,2'd1,1'b0,5'd0,32'd0,32'd0,32'h80000000,4'b0000,32'h00000000,4'b0110,1'b1,8'd3},
    '{4'd13,1'b1,1'b0,8'h00,4'd0,2'd1,1'b0,5'd1,32'd0,32'd0,32'h00000003,4'b0000,32'h00000001,4'b0010,1'b1,8'd3},
    '{4'd13,1'b1,1'b0,8'h00,4'd0,2'd1,1'b1,5'd0,32'd32,32'd0,32'h80000000,4'b0000,32'h00000000,4'b0110,1'b1,8'd3},
    '{4'd13,1'b1,1'b0,8'h00,4'd0,2'd1,1'b1,5'd0,32'd40,32'd0,32'hFFFFFFFF,4'b0010,32'h00000000,4'b0100,1'b1,8'd3},
    // R4 arithmetic right shift
    '{4'd13,1'b1,1'b0,8'h00,4'd0,2'd2,1'b0,5'd0,32'd0,32'd0,32'h80000000,4'b0000,32'hFFFFFFFF,4'b1010,1'b1,8'd4},
    '{4'd13,1'b1,1'b0,8'h00,4'd0,2'd2,1'b1,5'd0,32'd200,32'd0,32'h7FFFFFFF,4'b0010,32'h00000000,4'b0100,1'b1,8'd4},
    '{4'd13,1'b1,1'b0,8'h00,4'd0,2'd2,1'b0,5'd4,32'd0,32'd0,32'h80000010,4'b0010,32'hF8000001,4'b1000,1'b1,8'd4},
    // R5 rotate through carry
    '{4'd13,1'b1,1'b0,8'h00,4'd0,2'd3,1'b0,5'd0,32'd0,32'd0,32'h00000001,4'b0010,32'h80000000,4'b1010,1'b1,8'd5},
    '{4'd13,1'b1,1'b0,8'h00,4'd0,2'd3,1'b0,5'd0,32'd0,32'd0,32'h00000003,4'b0000,32'h00000001,4'b0010,1'b1,8'd5},
    // R6 rotate by register
    '{4'd13,1'b1,1'b0,8'h00,4'd0,2'd3,1'b1,5'd0,32'd0,32'd0,32'h00000001,4'b0010,32'h00000001,4'b0010,1'b1,8'd6},
    '{4'd13,1'b1,1'b0,8'h00,4'd0,2'd3,1'b1,5'd0,32'd32,32'd0,32'h80000000,4'b0000,32'h80000000,4'b1010,1'b1,8'd6},
    '{4'd13,1'b1,1'b0,8'h00,4'd0,2'd3,1'b1,5'd0,32'd8,32'd0,32'h000000AB,4'b0000,32'hAB000000,4'b1010,1'b1,8'd6},
    // R7 only low byte of register amount
    '{4'd13,1'b1,1'b0,8'h00,4'd0,2'd0,1'b1,5'd0,32'h00000104,32'd0,32'h00000001,4'b0010,32'h00000010,4'b0000,1'b1,8'd7},
    '{4'd13,1'b1,1'b0,8'h00,4'd0,2'd1,1'b1,5'd0,32'hFFFFFF20,32'd0,32'h80000000,4'b0000,32'h00000000,4'b0110,1'b1,8'd7},
    // R8 logical operations
    '{4'd0,1'b1,1'b0,8'h00,4'd0,2'd0,1'b0,5'd0,32'd0,32'hF0F0F0F0,32'h0F0F0F0F,4'b0011,32'h00000000,4'b0111,1'b1,8'd8},
    '{4'd1,1'b1,1'b0,8'h00,4'd0,2'd0,1'b0,5'd0,32'd0,32'hFFFF0000,32'h0000FFFF,4'b0001,32'hFFFFFFFF,4'b1001,1'b1,8'd8},
    '{4'd14,1'b1,1'b0,8'h00,4'd0,2'd0,1'b0,5'd0,32'd0,32'hFFFFFFFF,32'h0000FFFF,4'b0000,32'hFFFF0000,4'b1000,1'b1,8'd8},
    '{4'd15,1'b1,1'b0,8'h00,4'd0,2'd1,1'b0,5'd1,32'd0,32'd0,32'h00000001,4'b0000,32'hFFFFFFFF,4'b1010,1'b1,8'd8},
    '{4'd12,1'b1,1'b0,8'h00,4'd0,2'd0,1'b0,5'd0,32'd0,32'h00000F00,32'h000000F0,4'b0001,32'h00000FF0,4'b0001,1'b1,8'd8},
    // R9 arithmetic operations
    '{4'd4,1'b1,1'b0,8'h00,4'd0,2'd0,1'b0,5'd0,32'd0,32'h7FFFFFFF,32'h00000001,4'b0000,32'h80000000,4'b1001,1'b1,8'd9},
    '{4'd4,1'b1,1'b0,8'h00,4'd0,2'd0,1'b0,5'd0,32'd0,32'hFFFFFFFF,32'h00000001,4'b0000,32'h00000000,4'b0110,1'b1,8'd9},
    '{4'd2,1'b1,1'b0,8'h00,4'd0,2'd0,1'b0,5'd0,32'd0,32'h00000005,32'h00000005,4'b0000,32'h00000000,4'b0110,1'b1,8'd9},
    '{4'd2,1'b1,1'b0,8'h00,4'd0,2'd0,1'b0,5'd0,32'd0,32'h00000003,32'h00000005,4'b0010,32'hFFFFFFFE,4'b1000,1'b1,8'd9},
    '{4'd2,1'b1,1'b0,8'h00,4'd0,2'd0,1'b0,5'd0,32'd0,32'h80000000,32'h00000001,4'b0000,32'h7FFFFFFF,4'b0011,1'b1,8'd9},
    '{4'd3,1'b1,1'b0,8'h00,4'd0,2'd0,1'b0,5'd0,32'd0,32'h00000001,32'h00000003,4'b0000,32'h00000002,4'b0010,1'b1,8'd9},
    '{4'd5,1'b1,1'b0,8'h00,4'd0,2'd0,1'b0,5'd0,32'd0,32'h00000001,32'h00000001,4'b0010,32'h00000003,4'b0000,1'b1,8'd9},
    '{4'd6,1'b1,1'b0,8'h00,4'd0,2'd0,1'b0,5'd0,32'd0,32'h00000005,32'h00000003,4'b0000,32'h00000001,4'b0010,1'b1,8'd9},
    '{4'd7,1'b1,1'b0,8'h00,4'd0,2'd0,1'b0,5'd0,32'd0,32'h00000003,32'h00000005,4'b0010,32'h00000002,4'b0010,1'b1,8'd9},
    // R10 compare and test, set_flags low
    '{4'd10,1'b0,1'b0,8'h00,4'd0,2'd0,1'b0,5'd0,32'd0,32'h00000005,32'h00000005,4'b0000,32'h00000000,4'b0110,1'b0,8'd10},
    '{4'd8,1'b0,1'b0,8'h00,4'd0,2'd0,1'b0,5'd0,32'd0,32'h000000F0,32'h0000000F,4'b0001,32'h00000000,4'b0101,1'b0,8'd10},
    '{4'd11,1'b0,1'b0,8'h00,4'd0,2'd0,1'b0,5'd0,32'd0,32'hFFFFFFFF,32'h00000001,4'b1000,32'h00000000,4'b0110,1'b0,8'd10},
    // R11 no flag update
    '{4'd4,1'b0,1'b0,8'h00,4'd0,2'd0,1'b0,5'd0,32'd0,32'h7FFFFFFF,32'h00000001,4'b0101,32'h80000000,4'b0101,1'b1,8'd11},
    '{4'd13,1'b0,1'b0,8'h00,4'd0,2'd1,1'b0,5'd0,32'd0,32'd0,32'h80000000,4'b0000,32'h00000000,4'b0000,1'b1,8'd11}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [3:0]  alu_op = '0;
  logic        set_flags = 1'b0;
  logic        imm_form = 1'b0;
  logic [7:0]  imm_byte = '0;
  logic [3:0]  imm_rot = '0;
  logic [1:0]  sh_kind = '0;
  logic        sh_by_reg = 1'b0;
  logic [4:0]  sh_amt_imm = '0;
  logic [31:0] sh_amt_reg = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [3:0]  flags_in = '0;
  logic        out_vld;
  logic [31:0] result;
  logic [3:0]  flags_out;
  logic        dest_we;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  sau_top u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .alu_op(alu_op), .set_flags(set_flags),
    .imm_form(imm_form), .imm_byte(imm_byte), .imm_rot(imm_rot), .sh_kind(sh_kind),
    .sh_by_reg(sh_by_reg), .sh_amt_imm(sh_amt_imm), .sh_amt_reg(sh_amt_reg),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_in(flags_in), .out_vld(out_vld),
    .result(result), .flags_out(flags_out), .dest_we(dest_we)
  );

  task automatic drive(input vec_t t, input logic vld);
    in_vld = vld; alu_op = t.op; set_flags = t.sf; imm_form = t.imf;
    imm_byte = t.ib; imm_rot = t.ir; sh_kind = t.k; sh_by_reg = t.br;
    sh_amt_imm = t.ai; sh_amt_reg = t.ar; opnd_a = t.a; opnd_b = t.b; flags_in = t.fi;
  endtask

  task automatic check(input string tag, input logic [31:0] er, input logic [3:0] ef,
                       input logic ew, input logic ev);
    n_chk++;
    if (result !== er || flags_out !== ef || dest_we !== ew || out_vld !== ev) begin
      n_bad++;
      $display("FAIL %s: result=%h flags=%b we=%b vld=%b expected result=%h flags=%b we=%b vld=%b",
               tag, result, flags_out, dest_we, out_vld, er, ef, ew, ev);
    end
  endtask

  initial begin
    vec_t hv;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset", 32'd0, 4'b0000, 1'b0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i], 1'b1);
      @(negedge clk);
      check($sformatf("R%0d vec %0d", TBL[i].req, i), TBL[i].er, TBL[i].ef, TBL[i].ew, 1'b1);
    end

    // R12 idle cycle holds outputs: ADD 2+3 with flags set, then idle with other data
    hv = '{4'd4,1'b1,1'b0,8'h00,4'd0,2'd0,1'b0,5'd0,32'd0,32'd2,32'd3,4'b0000,32'd5,4'b0000,1'b1,8'd12};
    @(negedge clk);
    drive(hv, 1'b1);
    @(negedge clk);
    check("R12 latency", 32'd5, 4'b0000, 1'b1, 1'b1);
    hv.a = 32'hFFFFFFFF; hv.b = 32'h1; hv.op = 4'd10;
    drive(hv, 1'b0);
    @(negedge clk);
    check("R12 idle hold", 32'd5, 4'b0000, 1'b1, 1'b0);

    // R12 reset mid-stream clears registered outputs
    hv = '{4'd13,1'b1,1'b0,8'h00,4'd0,2'd0,1'b0,5'd0,32'd0,32'd0,32'h80000000,4'b0001,32'h80000000,4'b1001,1'b1,8'd12};
    drive(hv, 1'b1);
    @(negedge clk);
    check("R12 before reset", 32'h80000000, 4'b1001, 1'b1, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R12 sync reset", 32'd0, 4'b0000, 1'b0, 1'b0);
    rst = 1'b0;
    in_vld = 1'b0;
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule